// File: doc/BRIEF.md
# UART Transmit Path

This block is the serializing half of a UART. Bytes come in from the host side over a valid/ready write port and are placed in a byte-wide transmit queue. A frame shifter takes them from there one at a time and drives them out on a single TX line. Bit timing comes from a one-cycle `baud_tick` strobe supplied from outside. Each tick ends one bit period. Word length, parity and stop-bit count are plain control inputs. They are captured when a byte enters the shifter, and they should be held steady while `tx_empty` is 0.

The queue has two modes. With `fifo_en` high it holds up to 32 bytes. With `fifo_en` low it acts as a single holding register. The block reports two status flags. `hold_empty` says the queue or holding register has room and nothing waiting. `tx_empty` says the queue and the shift register are both idle, so the line has finished its last stop bit. The write port applies back-pressure through `wr_ready`. A byte is taken only in a cycle where `wr_valid` and `wr_ready` are both high. A byte offered while `wr_ready` is low is not stored. The host may hold it or withdraw it.

Top module: `uart_tx_path`

## Requirements
- R1: After reset `tx_out`, `hold_empty`, `tx_empty` and `wr_ready` all read 1.
- R2: A frame is a start bit of 0, then 5+`word_len` data bits LSB first (`word_len` 0..3 gives 5..8 bits), then a parity bit if `par_en` is 1, then one stop bit of 1 (two if `two_stop` is 1). The parity bit makes the count of ones over the data bits and the parity bit even when `par_odd` is 0, and odd when it is 1. `tx_out` changes only on the clock edge where `baud_tick` is high.
- R3: With `fifo_en` high the queue accepts 32 bytes before `wr_ready` drops. Accepted bytes are sent in the order written, and none is lost.
- R4: A byte offered while `wr_ready` is low is not stored and is never transmitted.
- R5: `hold_empty` is 0 in the cycle after any accepted write.
- R6: `hold_empty` returns to 1 only after a clock edge with `baud_tick` high, namely the one at which the last waiting byte moves into the shift register.
- R7: With `fifo_en` low, storage holds one byte: `wr_ready` is 0 while a byte waits in the holding register.
- R8: `tx_empty` is 1 only when nothing waits in storage and the shift register is idle. The line is at 1 whenever `tx_empty` is 1. When the last byte moves into the shift register, `hold_empty` rises but `tx_empty` stays 0.
- R9: A byte that is waiting when a stop bit ends starts its start bit at the next bit period, with no idle period between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 32-byte queue, 0: single holding register |
| baud_tick | input | 1 | One-cycle strobe marking the end of each bit period |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | 1: two stop bits |
| par_en | input | 1 | 1: append a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte offered |
| wr_ready | output | 1 | Storage has room |
| tx_out | output | 1 | Serial line, idles at 1 |
| hold_empty | output | 1 | Nothing waits in queue/holding register |
| tx_empty | output | 1 | Queue and shift register both idle |

## Verification
The bench fills the 32-byte queue with the bit clock stopped and then offers one more byte. A design that stored the extra byte, or overwrote the oldest one, would send a frame the decoder does not expect or lose one it does. While the full queue drains, the decoder records the bit period of every start bit and checks that it directly follows the previous last stop bit, which catches a shifter that idles for a period between frames. A separate case checks the moment the last byte leaves storage. A design that tied the two flags together would raise `tx_empty` while the frame is still on the line, and one that raised `hold_empty` late would hold off the next write. In single-register mode a second write must wait, and a design that ignored the mode would accept it. Random bursts sweep every word length, parity and stop setting against a decoder that builds each expected frame from the requirements.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int FRAME_MAX = 12;
  localparam int LEN_W = 4;

  typedef struct packed {
    logic [1:0] word_len;
    logic       two_stop;
    logic       par_en;
    logic       par_odd;
  } tx_cfg_t;

  // Full line image of one character, bit 0 first; unused high bits stay 1.
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] d, input tx_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    logic p;
    int n;
    n = 5 + int'(c.word_len);
    f = '1;
    f[0] = 1'b0;
    p = c.par_odd;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        f[1+i] = d[i];
        p = p ^ d[i];
      end
    end
    if (c.par_en) f[1+n] = p;
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input tx_cfg_t c);
    return LEN_W'(7) + LEN_W'(c.word_len) + LEN_W'(c.par_en) + LEN_W'(c.two_stop);
  endfunction
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_mode,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic do_push, do_pop;

  assign cap        = single_mode ? CW'(1) : CW'(DEPTH);
  assign push_ready = (count < cap);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && (count != '0);
  assign empty      = (count == '0);
  assign pop_data   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       src_valid,
  input  logic [7:0] src_data,
  input  tx_cfg_t    cfg,
  output logic       src_take,
  output logic       tx_out,
  output logic       busy
);
  logic [FRAME_MAX-1:0] sh;
  logic [LEN_W-1:0]     left;
  logic                 at_end;

  // Idle or in the final bit period: ready to start the next frame on this tick.
  assign at_end   = (left <= LEN_W'(1));
  assign src_take = tick && src_valid && at_end;
  assign busy     = (left != '0);
  assign tx_out   = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
    end else if (tick) begin
      if (src_take) begin
        sh   <= build_frame(src_data, cfg);
        left <= frame_len(cfg);
      end else if (left != '0) begin
        sh   <= {1'b1, sh[FRAME_MAX-1:1]};
        left <= left - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       baud_tick,
  input  logic [1:0] word_len,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       tx_out,
  output logic       hold_empty,
  output logic       tx_empty
);
  tx_cfg_t       cfg;
  logic          take, q_empty, sh_busy;
  logic [7:0]    q_data;
  logic [CW-1:0] fill_count;

  assign cfg = '{word_len: word_len, two_stop: two_stop, par_en: par_en, par_odd: par_odd};

  uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .single_mode(!fifo_en),
    .push_valid (wr_valid),
    .push_data  (wr_data),
    .push_ready (wr_ready),
    .pop        (take),
    .pop_data   (q_data),
    .empty      (q_empty),
    .count      (fill_count)
  );

  uart_tx_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .src_valid(!q_empty),
    .src_data (q_data),
    .cfg      (cfg),
    .src_take (take),
    .tx_out   (tx_out),
    .busy     (sh_busy)
  );

  assign hold_empty = q_empty;
  assign tx_empty   = q_empty && !sh_busy;
endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          baud_tick,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          tx_out,
  input logic          hold_empty,
  input logic          tx_empty,
  input logic [CW-1:0] fill
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_hold_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !hold_empty);

  p_hold_sets_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(baud_tick));

  p_single_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && fill != '0) |-> !wr_ready);

  p_empty_nests_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (hold_empty && tx_out));

  p_line_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_out));
endmodule

bind uart_tx_path uart_tx_path_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_en   (fifo_en),
  .baud_tick (baud_tick),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .tx_out    (tx_out),
  .hold_empty(hold_empty),
  .tx_empty  (tx_empty),
  .fill      (fill_count)
);

// File: tb/uart_tx_path_bench.sv
`timescale 1ns/1ps
module uart_tx_path_bench;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, baud_tick = 0;
  logic [1:0] word_len = 3;
  logic two_stop = 0, par_en = 0, par_odd = 0;
  logic wr_valid = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, tx_out, hold_empty, tx_empty;

  uart_tx_path u_uart_tx_path (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int cycles = 0;
  bit tick_en = 0;
  int div = 0;
  bit tick_seen = 0;
  int tick_idx = 0;

  // bench reference state
  byte unsigned exp_q[$];
  int  rx_st = 0, rx_cnt = 0, rx_frames = 0;
  logic [7:0] rx_data;
  logic rx_par, rx_ok;
  int  last_stop_idx = 0;
  bit  have_last = 0, b2b_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbits();
    return 5 + int'(word_len);
  endfunction

  function automatic logic [7:0] mask(input logic [7:0] d);
    return d & 8'((1 << nbits()) - 1);
  endfunction

  function automatic logic exp_parity(input logic [7:0] d);
    return (^mask(d)) ^ par_odd;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (tick_en) begin
      div = (div + 1) % 4;
      baud_tick = (div == 3);
    end else begin
      baud_tick = 0;
    end
  end

  always @(posedge clk) begin
    tick_seen <= baud_tick;
    if (baud_tick) tick_idx <= tick_idx + 1;
  end

  // Line decoder: samples tx_out once per bit period, after the tick edge.
  always @(negedge clk) begin
    if (rst_n && tick_seen) begin
      case (rx_st)
        0: if (!tx_out) begin
          if (b2b_on && have_last)
            chk(tick_idx == last_stop_idx + 1, "R9 start follows stop", tick_idx, last_stop_idx + 1);
          rx_st = 1; rx_cnt = 0; rx_data = 0; rx_ok = 1;
        end
        1: begin
          rx_data[rx_cnt] = tx_out;
          rx_cnt++;
          if (rx_cnt == nbits()) begin
            rx_st = par_en ? 2 : 3;
            rx_cnt = 0;
          end
        end
        2: begin rx_par = tx_out; rx_st = 3; end
        default: begin
          if (!tx_out) rx_ok = 0;
          rx_cnt++;
          if (rx_cnt == (two_stop ? 2 : 1)) begin
            rx_st = 0;
            last_stop_idx = tick_idx;
            have_last = 1;
            rx_frames++;
            if (exp_q.size() == 0) begin
              chk(0, "R4 unexpected frame", rx_data, -1);
            end else begin
              byte unsigned e;
              e = exp_q.pop_front();
              chk(rx_ok && rx_data == mask(e) && (!par_en || rx_par == exp_parity(e)),
                  "R2 frame content", rx_data, mask(e));
            end
          end
        end
      endcase
    end
  end

  task automatic send(input logic [7:0] d);
    wr_valid = 1;
    wr_data = d;
    while (!wr_ready) @(negedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(tx_out == 1, "R1 tx idle", tx_out, 1);
    chk(hold_empty == 1, "R1 hold_empty", hold_empty, 1);
    chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    rst_n = 1;
    @(negedge clk);
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);

    // single holding register
    fifo_en = 0; word_len = 3; par_en = 1; par_odd = 0; two_stop = 0;
    send(8'hA5);
    chk(hold_empty == 0, "R5 hold cleared", hold_empty, 0);
    chk(tx_empty == 0, "R8 tx_empty cleared", tx_empty, 0);
    chk(wr_ready == 0, "R7 one-byte capacity", wr_ready, 0);
    wr_valid = 1; wr_data = 8'h3C;
    repeat (4) @(negedge clk);
    chk(wr_ready == 0, "R4 blocked write", wr_ready, 0);
    wr_valid = 0;
    tick_en = 1;
    while (!tick_seen) @(negedge clk);
    chk(hold_empty == 1, "R6 hold set at transfer", hold_empty, 1);
    chk(tx_empty == 0, "R8 shifter still busy", tx_empty, 0);
    wait_idle();
    chk(rx_frames == 1, "R4 dropped byte not sent", rx_frames, 1);
    chk(exp_q.size() == 0, "R3 all sent", exp_q.size(), 0);

    // fill the 32-byte queue with the bit clock stopped
    tick_en = 0;
    fifo_en = 1; word_len = 2; par_en = 1; par_odd = 1; two_stop = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) send(8'(i * 7 + 1));
    chk(wr_ready == 0, "R3 full at 32", wr_ready, 0);
    chk(hold_empty == 0, "R5 hold while full", hold_empty, 0);
    wr_valid = 1; wr_data = 8'hEE;
    repeat (3) @(negedge clk);
    wr_valid = 0;
    rx_frames = 0; have_last = 0; b2b_on = 1;
    tick_en = 1;
    while (!hold_empty) @(negedge clk);
    chk(tick_seen == 1, "R6 hold rises on tick", tick_seen, 1);
    chk(tx_empty == 0, "R8 last byte still shifting", tx_empty, 0);
    wait_idle();
    b2b_on = 0;
    chk(rx_frames == 32, "R4 overflow byte dropped", rx_frames, 32);
    chk(exp_q.size() == 0, "R3 order and count", exp_q.size(), 0);
    chk(tx_out == 1, "R8 line idle", tx_out, 1);

    // random bursts across settings
    for (int b = 0; b < 10; b++) begin
      int n;
      word_len = 2'($urandom_range(0, 3));
      par_en   = 1'($urandom_range(0, 1));
      par_odd  = 1'($urandom_range(0, 1));
      two_stop = 1'($urandom_range(0, 1));
      fifo_en  = 1'($urandom_range(0, 1));
      n = $urandom_range(1, 10);
      for (int k = 0; k < n; k++) begin
        send(8'($urandom));
        repeat ($urandom_range(0, 8)) @(negedge clk);
      end
      wait_idle();
      chk(exp_q.size() == 0, "R3 burst delivered", exp_q.size(), 0);
      chk(hold_empty && tx_empty, "R8 both flags idle", {hold_empty, tx_empty}, 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule